// File: doc/BRIEF.md
# I2C Memory Target with Masked Device Select

This block is the transaction layer of an I2C target that looks like a small byte-addressable nonvolatile memory. The storage is held in on-chip flip-flops. A bit-level front end, which is not part of this block, turns the bus into single-cycle event strobes: a START together with a 7-bit device address and a direction bit, a STOP, a received write byte, and a request for the next read byte. The block answers every address and write event with an acknowledge decision. It answers every read request with a data byte.

A device address selects the target when the bits kept by a mask parameter agree with the same bits of a base address parameter. A selected write transaction first loads an internal pointer from one or two address bytes, most significant byte first. Further write bytes are stored at the pointer. Read requests return the byte at the pointer. After each stored or returned byte the pointer advances and wraps at the configured size. That size is the smaller of the requested size and the physical capacity. The number of address bytes follows from it.

Top module: `i2cmem_target`

## Requirements
- R1: After reset the target is not selected, no response strobe is high, and every storage location reads back as 0xFF.
- R2: A START whose 7-bit address matches the base under the mask (`(addr & MASK) == (BASE & MASK)`) is acknowledged (ack = 1) and selects the target. The matching address is held on `sel_addr`.
- R3: A START whose address does not match under the mask is answered with ack = 0 and leaves the target deselected.
- R4: In a selected write transaction, the first address bytes after each START load the pointer, most significant byte first. There are two such bytes when the effective size exceeds 256 and one byte otherwise.
- R5: Each write byte after the address bytes of a selected write transaction (direction bit 0) is acknowledged and stored at the pointer, and the pointer then advances by one.
- R6: A read request while selected returns the byte at the pointer and then advances the pointer by one.
- R7: The pointer wraps to zero after the last location of the effective size, which is a power of two.
- R8: The effective size is the configured size clamped to the physical capacity. Address bits above that size are dropped.
- R9: A STOP deselects the target and clears the address-byte count. A later write byte is answered with ack = 0 and is not stored.
- R10: Every START clears the address-byte count, so a repeated START begins a fresh address phase or read.
- R11: A write byte during a selected read transaction (direction bit 1) is answered with ack = 0 and not stored. A read request while deselected returns 0xFF and does not move the pointer.
- R12: Each acknowledge or read response appears in the clock cycle right after its event strobe. When strobes coincide, the priority is START, then STOP, then write byte, then read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ev_start | input | 1 | START (or repeated START) with address strobe |
| ev_stop | input | 1 | STOP strobe |
| ev_wbyte | input | 1 | Write byte received strobe |
| ev_rreq | input | 1 | Next read byte requested strobe |
| ev_addr | input | 7 | Device address sent with the START |
| ev_rnw | input | 1 | Direction sent with the START, 1 = read |
| ev_data | input | 8 | Byte received with a write strobe |
| ack_valid | output | 1 | Acknowledge decision is valid |
| ack | output | 1 | 1 = acknowledge, 0 = no acknowledge |
| rd_valid | output | 1 | Read byte is valid |
| rd_data | output | 8 | Byte to shift out |
| selected | output | 1 | Target is taking part in the current transaction |
| sel_addr | output | 7 | Device address held since the last matching START |

## Verification
The memory function is tried with four patterns. Sequential write and read-back at a mid-range address shows that data lands where the two-byte pointer says and keeps its order. A run across the top location separates a correct wrap from a pointer that runs past the end. A repeated START between the address phase and the read shows that the byte count restarts, where a missing clear would treat the read as more address bytes. Writes after STOP, after a non-matching address, or inside a read transaction are followed by a read-back of the location they would have touched. A second instance with a one-byte address and a clamped size shows the dropped high address bits and the shorter address phase.

// File: rtl/i2cmem_pkg.sv
package i2cmem_pkg;

  typedef enum logic [2:0] {
    EVK_NONE  = 3'd0,
    EVK_START = 3'd1,
    EVK_STOP  = 3'd2,
    EVK_WBYTE = 3'd3,
    EVK_RREQ  = 3'd4
  } ev_kind_e;

  function automatic int min_int(input int a, input int b);
    return (a < b) ? a : b;
  endfunction

  function automatic int log2_ceil(input int v);
    int r;
    r = 0;
    while ((1 << r) < v) r++;
    return (r < 1) ? 1 : r;
  endfunction

endpackage

// File: rtl/i2cmem_match.sv
module i2cmem_match #(
  parameter logic [6:0] BASE = 7'h50,
  parameter logic [6:0] MASK = 7'h78
) (
  input  logic [6:0] addr,
  output logic       hit
);
  localparam logic [6:0] BASE_M = BASE & MASK;

  always_comb begin
    hit = ((addr & MASK) == BASE_M);
  end
endmodule

// File: rtl/i2cmem_ctrl.sv
module i2cmem_ctrl
  import i2cmem_pkg::*;
#(
  parameter int PTR_W  = 9,
  parameter int ABYTES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_start,
  input  logic             ev_stop,
  input  logic             ev_wbyte,
  input  logic             ev_rreq,
  input  logic [6:0]       ev_addr,
  input  logic             ev_rnw,
  input  logic [7:0]       ev_data,
  input  logic             hit,
  output logic             ack_valid,
  output logic             ack,
  output logic             selected,
  output logic [6:0]       sel_addr,
  output logic [PTR_W-1:0] ptr,
  output logic             wr_en,
  output logic [7:0]       wr_data,
  output logic             rd_req,
  output logic             rd_en
);
  localparam logic [1:0] ABYTES_L = 2'(ABYTES);

  ev_kind_e         kind;
  logic             act_q, act_n;
  logic             rnw_q, rnw_n;
  logic [6:0]       sel_q, sel_n;
  logic [1:0]       idx_q, idx_n;
  logic [PTR_W-1:0] ptr_q, ptr_n;
  logic             ackv_q, ackv_n;
  logic             ack_q, ack_n;

  // priority decode of coincident strobes
  always_comb begin
    if (ev_start)      kind = EVK_START;
    else if (ev_stop)  kind = EVK_STOP;
    else if (ev_wbyte) kind = EVK_WBYTE;
    else if (ev_rreq)  kind = EVK_RREQ;
    else               kind = EVK_NONE;
  end

  always_comb begin
    act_n  = act_q;
    rnw_n  = rnw_q;
    sel_n  = sel_q;
    idx_n  = idx_q;
    ptr_n  = ptr_q;
    ackv_n = 1'b0;
    ack_n  = 1'b0;
    wr_en  = 1'b0;
    rd_req = 1'b0;
    rd_en  = 1'b0;
    unique case (kind)
      EVK_START: begin
        idx_n  = 2'd0;
        ackv_n = 1'b1;
        if (hit) begin
          act_n = 1'b1;
          rnw_n = ev_rnw;
          sel_n = ev_addr;
          ack_n = 1'b1;
        end else begin
          act_n = 1'b0;
        end
      end
      EVK_STOP: begin
        act_n = 1'b0;
        idx_n = 2'd0;
      end
      EVK_WBYTE: begin
        ackv_n = 1'b1;
        if (act_q && !rnw_q) begin
          ack_n = 1'b1;
          if (idx_q < ABYTES_L) begin
            if (idx_q == 2'd0) ptr_n = PTR_W'(ev_data);
            else               ptr_n = PTR_W'({ptr_q, ev_data});
            idx_n = idx_q + 2'd1;
          end else begin
            wr_en = 1'b1;
            ptr_n = ptr_q + 1'b1;
          end
        end
      end
      EVK_RREQ: begin
        rd_req = 1'b1;
        if (act_q) begin
          rd_en = 1'b1;
          ptr_n = ptr_q + 1'b1;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      rnw_q  <= 1'b0;
      sel_q  <= 7'd0;
      idx_q  <= 2'd0;
      ptr_q  <= '0;
      ackv_q <= 1'b0;
      ack_q  <= 1'b0;
    end else begin
      act_q  <= act_n;
      rnw_q  <= rnw_n;
      sel_q  <= sel_n;
      idx_q  <= idx_n;
      ptr_q  <= ptr_n;
      ackv_q <= ackv_n;
      ack_q  <= ack_n;
    end
  end

  assign ack_valid = ackv_q;
  assign ack       = ack_q;
  assign selected  = act_q;
  assign sel_addr  = sel_q;
  assign ptr       = ptr_q;
  assign wr_data   = ev_data;

  p_match_selects_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_start && hit) |=> (selected && ack_valid && ack && sel_addr == $past(ev_addr)));

  p_miss_deselects_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_start && !hit) |=> (!selected && ack_valid && !ack));

  p_addr_count_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    idx_q <= ABYTES_L);

  p_data_acked_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == EVK_WBYTE && act_q && !rnw_q) |=> (ack_valid && ack));

  p_read_advances_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == EVK_RREQ && act_q) |=> (ptr == PTR_W'($past(ptr) + 1'b1)));

  p_stop_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == EVK_STOP) |=> (!selected && idx_q == 2'd0));

  p_start_restarts_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ev_start |=> (idx_q == 2'd0));

  p_read_dir_nack_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == EVK_WBYTE && act_q && rnw_q) |=> (ack_valid && !ack && $stable(ptr)));

endmodule

// File: rtl/i2cmem_store.sv
module i2cmem_store #(
  parameter int DEPTH = 512,
  parameter int PTR_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [PTR_W-1:0] ptr,
  input  logic [7:0]       wr_data,
  input  logic             rd_req,
  input  logic             rd_en,
  output logic             rd_valid,
  output logic [7:0]       rd_data
);
  logic [DEPTH*8-1:0] cells;
  logic               rdv_q;
  logic [7:0]         rdd_q, rdd_n;

  for (genvar g = 0; g < DEPTH; g++) begin : g_cell
    logic [7:0] byte_q;
    logic       cell_we;
    assign cell_we = wr_en && (ptr == PTR_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       byte_q <= 8'hFF;
      else if (cell_we) byte_q <= wr_data;
    end
    assign cells[g*8 +: 8] = byte_q;
  end

  always_comb begin
    rdd_n = rdd_q;
    if (rd_req) rdd_n = rd_en ? cells[ptr*8 +: 8] : 8'hFF;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdv_q <= 1'b0;
      rdd_q <= 8'hFF;
    end else begin
      rdv_q <= rd_req;
      rdd_q <= rdd_n;
    end
  end

  assign rd_valid = rdv_q;
  assign rd_data  = rdd_q;

  p_read_one_cycle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> rd_valid);

  p_idle_read_high_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rd_en) |=> (rd_data == 8'hFF));

endmodule

// File: rtl/i2cmem_target.sv
module i2cmem_target
  import i2cmem_pkg::*;
#(
  parameter logic [6:0] BASE_ADDR  = 7'h50,
  parameter logic [6:0] ADDR_MASK  = 7'h78,
  parameter int         CFG_BYTES  = 512,
  parameter int         PHYS_BYTES = 512
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ev_start,
  input  logic       ev_stop,
  input  logic       ev_wbyte,
  input  logic       ev_rreq,
  input  logic [6:0] ev_addr,
  input  logic       ev_rnw,
  input  logic [7:0] ev_data,
  output logic       ack_valid,
  output logic       ack,
  output logic       rd_valid,
  output logic [7:0] rd_data,
  output logic       selected,
  output logic [6:0] sel_addr
);
  localparam int SIZE   = min_int(CFG_BYTES, PHYS_BYTES);
  localparam int PTR_W  = log2_ceil(SIZE);
  localparam int ABYTES = (SIZE > 256) ? 2 : 1;

  // asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_n_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  logic             hit;
  logic [PTR_W-1:0] ptr;
  logic             wr_en;
  logic [7:0]       wr_data;
  logic             rd_req;
  logic             rd_en;

  i2cmem_match #(.BASE(BASE_ADDR), .MASK(ADDR_MASK)) u_match (
    .addr (ev_addr),
    .hit  (hit)
  );

  i2cmem_ctrl #(.PTR_W(PTR_W), .ABYTES(ABYTES)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .ev_start  (ev_start),
    .ev_stop   (ev_stop),
    .ev_wbyte  (ev_wbyte),
    .ev_rreq   (ev_rreq),
    .ev_addr   (ev_addr),
    .ev_rnw    (ev_rnw),
    .ev_data   (ev_data),
    .hit       (hit),
    .ack_valid (ack_valid),
    .ack       (ack),
    .selected  (selected),
    .sel_addr  (sel_addr),
    .ptr       (ptr),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .rd_req    (rd_req),
    .rd_en     (rd_en)
  );

  i2cmem_store #(.DEPTH(SIZE), .PTR_W(PTR_W)) u_store (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .wr_en    (wr_en),
    .ptr      (ptr),
    .wr_data  (wr_data),
    .rd_req   (rd_req),
    .rd_en    (rd_en),
    .rd_valid (rd_valid),
    .rd_data  (rd_data)
  );

  p_quiet_after_reset_r1: assert property (@(posedge clk) disable iff (!rst_n_s)
    $rose(rst_n_s) |-> (!selected && !ack_valid && !rd_valid));

  p_one_response_r12: assert property (@(posedge clk) disable iff (!rst_n_s)
    (ev_start || ev_wbyte) |=> ack_valid);

endmodule

// File: tb/sim_i2cmem_target.sv
`timescale 1ns/1ps
module sim_i2cmem_target;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [1:0] s_start, s_stop, s_wb, s_rr, s_rnw;
  logic [6:0] s_addr [2];
  logic [7:0] s_data [2];
  logic [1:0] o_ackv, o_ack, o_rdv, o_act;
  logic [7:0] o_rd  [2];
  logic [6:0] o_sel [2];

  int nchk = 0;
  int nfail = 0;
  int q0[$], q1[$];
  string t0[$], t1[$];

  i2cmem_target #(.BASE_ADDR(7'h50), .ADDR_MASK(7'h78), .CFG_BYTES(512), .PHYS_BYTES(512)) u0 (
    .clk(clk), .rst_n(rst_n),
    .ev_start(s_start[0]), .ev_stop(s_stop[0]), .ev_wbyte(s_wb[0]), .ev_rreq(s_rr[0]),
    .ev_addr(s_addr[0]), .ev_rnw(s_rnw[0]), .ev_data(s_data[0]),
    .ack_valid(o_ackv[0]), .ack(o_ack[0]), .rd_valid(o_rdv[0]), .rd_data(o_rd[0]),
    .selected(o_act[0]), .sel_addr(o_sel[0])
  );

  i2cmem_target #(.BASE_ADDR(7'h50), .ADDR_MASK(7'h7F), .CFG_BYTES(256), .PHYS_BYTES(64)) u1 (
    .clk(clk), .rst_n(rst_n),
    .ev_start(s_start[1]), .ev_stop(s_stop[1]), .ev_wbyte(s_wb[1]), .ev_rreq(s_rr[1]),
    .ev_addr(s_addr[1]), .ev_rnw(s_rnw[1]), .ev_data(s_data[1]),
    .ack_valid(o_ackv[1]), .ack(o_ack[1]), .rd_valid(o_rdv[1]), .rd_data(o_rd[1]),
    .selected(o_act[1]), .sel_addr(o_sel[1])
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // expected item: kind*256 + value, kind 1 = ack, 2 = read byte
  task automatic push(input int u, input int item, input string tag);
    if (u == 0) begin q0.push_back(item); t0.push_back(tag); end
    else        begin q1.push_back(item); t1.push_back(tag); end
  endtask

  task automatic pop_cmp(input int u, input int got);
    int exp;
    string tag;
    if ((u == 0 && q0.size() == 0) || (u == 1 && q1.size() == 0)) begin
      check(1'b0, "R12 unexpected response", got, 0);
    end else begin
      if (u == 0) begin exp = q0.pop_front(); tag = t0.pop_front(); end
      else        begin exp = q1.pop_front(); tag = t1.pop_front(); end
      check(got == exp, tag, got, exp);
    end
  endtask

  // monitor: responses are registered, sampled at the falling edge
  always @(negedge clk) begin
    for (int u = 0; u < 2; u++) begin
      if (rst_n && o_ackv[u]) pop_cmp(u, 256 + int'(o_ack[u]));
      if (rst_n && o_rdv[u])  pop_cmp(u, 512 + int'(o_rd[u]));
    end
  end

  task automatic finish_ev(input int u);
    @(negedge clk);
    s_start[u] = 1'b0; s_stop[u] = 1'b0; s_wb[u] = 1'b0; s_rr[u] = 1'b0;
    #1;
    check((u == 0) ? (q0.size() == 0) : (q1.size() == 0), "R12 response one cycle late or missing", 0, 0);
  endtask

  task automatic do_start(input int u, input logic [6:0] a, input logic rnw, input bit exp_ack, input string tag);
    s_start[u] = 1'b1; s_addr[u] = a; s_rnw[u] = rnw;
    push(u, 256 + int'(exp_ack), tag);
    finish_ev(u);
  endtask

  task automatic do_stop(input int u);
    s_stop[u] = 1'b1;
    finish_ev(u);
  endtask

  task automatic do_wb(input int u, input logic [7:0] d, input bit exp_ack, input string tag);
    s_wb[u] = 1'b1; s_data[u] = d;
    push(u, 256 + int'(exp_ack), tag);
    finish_ev(u);
  endtask

  task automatic do_rr(input int u, input logic [7:0] exp, input string tag);
    s_rr[u] = 1'b1;
    push(u, 512 + int'(exp), tag);
    finish_ev(u);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    s_start = '0; s_stop = '0; s_wb = '0; s_rr = '0; s_rnw = '0;
    for (int u = 0; u < 2; u++) begin s_addr[u] = 7'd0; s_data[u] = 8'd0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check(o_act == 2'b00, "R1 selected after reset", o_act, 0);
    check(o_ackv == 2'b00 && o_rdv == 2'b00, "R1 strobes after reset", {o_ackv, o_rdv}, 0);

    // R11 read while deselected
    do_rr(0, 8'hFF, "R11 idle read");

    // R2, R4, R5 two-byte address then data
    do_start(0, 7'h53, 1'b0, 1'b1, "R2 masked match ack");
    check(o_act[0] && o_sel[0] == 7'h53, "R2 held address", o_sel[0], 7'h53);
    do_wb(0, 8'h01, 1'b1, "R4 address high ack");
    do_wb(0, 8'h23, 1'b1, "R4 address low ack");
    do_wb(0, 8'hAA, 1'b1, "R5 data ack");
    do_wb(0, 8'hBB, 1'b1, "R5 data ack");

    // R10 repeated start, R6 read, R1 untouched location
    do_start(0, 7'h53, 1'b0, 1'b1, "R2 ack");
    do_wb(0, 8'h01, 1'b1, "R4 ack");
    do_wb(0, 8'h23, 1'b1, "R4 ack");
    do_start(0, 7'h53, 1'b1, 1'b1, "R10 repeated start ack");
    do_rr(0, 8'hAA, "R6 read 0x123");
    do_rr(0, 8'hBB, "R6 read 0x124");
    do_rr(0, 8'hFF, "R1 erased byte 0x125");

    // R7 wrap at 0x1FF
    do_start(0, 7'h55, 1'b0, 1'b1, "R2 other masked address");
    do_wb(0, 8'h01, 1'b1, "R4 ack");
    do_wb(0, 8'hFF, 1'b1, "R4 ack");
    do_wb(0, 8'hCC, 1'b1, "R5 ack");
    do_wb(0, 8'hDD, 1'b1, "R7 ack after wrap");
    do_start(0, 7'h55, 1'b0, 1'b1, "R2 ack");
    do_wb(0, 8'h01, 1'b1, "R4 ack");
    do_wb(0, 8'hFF, 1'b1, "R4 ack");
    do_start(0, 7'h55, 1'b1, 1'b1, "R10 ack");
    do_rr(0, 8'hCC, "R7 read 0x1FF");
    do_rr(0, 8'hDD, "R7 read wrapped 0x000");
    do_rr(0, 8'hFF, "R7 read 0x001");

    // R3 non-matching address
    do_start(0, 7'h60, 1'b0, 1'b0, "R3 miss nack");
    check(o_act[0] == 1'b0, "R3 deselected", o_act[0], 0);
    do_wb(0, 8'h44, 1'b0, "R3 write while deselected nack");

    // R9 stop then write is ignored
    do_start(0, 7'h50, 1'b0, 1'b1, "R2 ack");
    do_wb(0, 8'h00, 1'b1, "R4 ack");
    do_wb(0, 8'h02, 1'b1, "R4 ack");
    do_stop(0);
    check(o_act[0] == 1'b0, "R9 deselected by stop", o_act[0], 0);
    do_wb(0, 8'h77, 1'b0, "R9 write after stop nack");
    do_start(0, 7'h50, 1'b0, 1'b1, "R2 ack");
    do_wb(0, 8'h00, 1'b1, "R9 address phase restarts");
    do_wb(0, 8'h02, 1'b1, "R9 address phase restarts");
    do_start(0, 7'h50, 1'b1, 1'b1, "R10 ack");
    do_rr(0, 8'hFF, "R9 byte 0x002 not written");

    // R11 write in read transaction; pointer now 0x003
    do_start(0, 7'h50, 1'b1, 1'b1, "R2 ack");
    do_wb(0, 8'h99, 1'b0, "R11 write in read nack");
    do_rr(0, 8'hFF, "R11 byte 0x003 not written");

    // second instance: exact mask, 64 bytes, one address byte
    do_start(1, 7'h51, 1'b0, 1'b0, "R3 exact mask miss");
    do_start(1, 7'h50, 1'b0, 1'b1, "R2 exact match");
    do_wb(1, 8'h3F, 1'b1, "R4 single address byte");
    do_wb(1, 8'h11, 1'b1, "R5 ack");
    do_wb(1, 8'h22, 1'b1, "R7 ack after wrap at 64");
    do_start(1, 7'h50, 1'b0, 1'b1, "R2 ack");
    do_wb(1, 8'h3F, 1'b1, "R4 ack");
    do_start(1, 7'h50, 1'b1, 1'b1, "R10 ack");
    do_rr(1, 8'h11, "R4 read 0x3F");
    do_rr(1, 8'h22, "R7 read wrapped 0x00");
    do_start(1, 7'h50, 1'b0, 1'b1, "R2 ack");
    do_wb(1, 8'h41, 1'b1, "R8 clamped address");
    do_wb(1, 8'h33, 1'b1, "R8 ack");
    do_start(1, 7'h50, 1'b0, 1'b1, "R2 ack");
    do_wb(1, 8'h01, 1'b1, "R8 ack");
    do_start(1, 7'h50, 1'b1, 1'b1, "R10 ack");
    do_rr(1, 8'h33, "R8 high bits dropped");

    repeat (3) @(negedge clk);
    check(q0.size() == 0 && q1.size() == 0, "R12 outstanding responses", q0.size() + q1.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule